// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and calendar date as packed binary-coded-decimal fields: two digits each for seconds, minutes, hours, day of month and month, four digits for the year, and a 3-bit weekday. A single-cycle enable, asserted once per second by an external prescaler, advances the time. Every carry, from seconds up to the year, settles in the same clock edge, so the fields never read back a half-updated value. Month lengths and the full Gregorian leap-year rule, including the century exceptions, are handled in hardware.

The block also gives a strobe for each accepted second and a second strobe each time the seconds units digit wraps. Both come straight from the digit carries. An alarm comparator checks hours, minutes, seconds and weekday against a programmed value. Any field can be masked out. The comparison is either exact equality or "current time at or past the alarm time". A synchronous load port sets the whole time and date at once.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Out of reset the time reads 00:00:00, weekday 0, day 8'h01, month 8'h01 and year 16'h2000. Both pulses, `alarm_hit` and `alarm_pend` are low. Each digit is a 4-bit BCD nibble in the range 0 to 9.
- R2: A high `tick_1hz` at a clock edge advances seconds by one. Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and advance the date. All affected fields change at that same edge.
- R3: With `tick_1hz` and `load_en` both low, no time or date field changes.
- R4: Day wraps to 01 and carries into the month after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and after day 28 or 29 in month 02.
- R5: February has day 29 only in leap years. A year is a leap year when it is divisible by 4. A year ending in 00 is a leap year only when it is divisible by 400.
- R6: The weekday advances by one at every date advance and wraps from 6 to 0.
- R7: Month wraps from 12 to 01 and increments the year. The year wraps from 9999 to 0000.
- R8: `pulse_1s` is high for exactly the one cycle after each accepted tick. `pulse_10s` is also high in that cycle when the tick moved the seconds units digit from 9 to 0.
- R9: In equality mode (`alarm_ge` = 0) the alarm matches when every unmasked field equals its alarm value. `alarm_mask` bit 0 ignores seconds, bit 1 ignores minutes, bit 2 ignores hours and bit 3 ignores weekday.
- R10: In at-or-past mode (`alarm_ge` = 1) the unmasked hour, minute and second fields, taken together as one number with hours most significant, must be greater than or equal to the alarm value. An unmasked weekday must still be equal.
- R11: A match that was absent in the previous cycle sets `alarm_pend` and raises `alarm_hit` for one cycle, one edge after the matching time appears. A match that persists does not raise them again. A match already present when reset is released is not taken as new. `alarm_clear` drops `alarm_pend`.
- R12: A `load_en` edge writes all load fields exactly and takes precedence over a tick in the same cycle. No pulse is produced at that edge, and `alarm_pend` and `alarm_hit` are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle enable per second |
| load_en | input | 1 | Synchronous load of all time and date fields |
| load_sec | input | 8 | BCD seconds to load |
| load_min | input | 8 | BCD minutes to load |
| load_hour | input | 8 | BCD hours to load |
| load_wday | input | 3 | Weekday to load, 0 to 6 |
| load_day | input | 8 | BCD day of month to load |
| load_mon | input | 8 | BCD month to load |
| load_year | input | 16 | BCD year to load |
| alarm_sec | input | 8 | Alarm seconds, BCD |
| alarm_min | input | 8 | Alarm minutes, BCD |
| alarm_hour | input | 8 | Alarm hours, BCD |
| alarm_wday | input | 3 | Alarm weekday |
| alarm_mask | input | 4 | Field ignore bits: 0 sec, 1 min, 2 hour, 3 weekday |
| alarm_ge | input | 1 | 1 selects at-or-past compare, 0 equality |
| alarm_clear | input | 1 | Clears the pending alarm |
| cur_sec | output | 8 | Current seconds, BCD |
| cur_min | output | 8 | Current minutes, BCD |
| cur_hour | output | 8 | Current hours, BCD |
| cur_wday | output | 3 | Current weekday |
| cur_day | output | 8 | Current day of month, BCD |
| cur_mon | output | 8 | Current month, BCD |
| cur_year | output | 16 | Current year, BCD |
| pulse_1s | output | 1 | Strobe per accepted tick |
| pulse_10s | output | 1 | Strobe when seconds units wrap |
| alarm_hit | output | 1 | One-cycle alarm event |
| alarm_pend | output | 1 | Alarm pending flag |

## Verification
The load port and the tick enable can act in the same cycle. At that moment an alarm may also be pending, or a new match may be rising. The bench puts the clock at an at-or-past match so that the flag is pending, then raises `load_en` and `tick_1hz` together at one edge. It then checks that the loaded value appears with no increment, that neither pulse fires and that the pending flag drops. A second coincidence is the date carry firing in the same edge as the seconds, minutes and hours wraps. This is judged by loading the last second of a year or a month and checking every field after the single tick.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FW = 8;        // two-digit BCD field
  localparam int YW = 16;       // four-digit BCD year
  localparam int WW = 3;        // weekday code
  localparam int YDIG = YW / 4;
  localparam logic [WW-1:0] WDAY_LAST = 3'd6;

  function automatic logic [FW-1:0] bcd_inc2(input logic [FW-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [YW-1:0] bcd_inc4(input logic [YW-1:0] v);
    logic [YW-1:0] r;
    logic c;
    r = v;
    c = 1'b1;
    for (int i = 0; i < YDIG; i++) begin
      if (c) begin
        if (r[i*4 +: 4] == 4'd9) r[i*4 +: 4] = 4'd0;
        else begin
          r[i*4 +: 4] = r[i*4 +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // two BCD digits divisible by four: even tens need 0/4/8, odd tens need 2/6
  function automatic logic bcd_div4(input logic [FW-1:0] v);
    if (v[4]) return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
    return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
  endfunction

  function automatic logic is_leap(input logic [YW-1:0] y);
    if (y[7:0] == 8'h00) return bcd_div4(y[15:8]);
    return bcd_div4(y[7:0]);
  endfunction

  function automatic logic [FW-1:0] month_len(input logic [FW-1:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd_wrap.sv
module cal_bcd_wrap
  import cal_pkg::*;
#(
  parameter logic [FW-1:0] FIRST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          ld,
  input  logic [FW-1:0] ld_val,
  input  logic [FW-1:0] last_val,
  output logic [FW-1:0] val,
  output logic          wrap
);
  logic [FW-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val_q <= FIRST;
    else if (ld)  val_q <= ld_val;
    else if (adv) val_q <= (val_q == last_val) ? FIRST : bcd_inc2(val_q);
  end

  assign val  = val_q;
  assign wrap = adv && !ld && (val_q == last_val);

  // R1: a units nine that is not the last value carries into the tens
  p_units_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && (val_q != last_val) && (val_q[3:0] == 4'h9)) |=> (val_q[3:0] == 4'h0));
endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          ld,
  input  logic [FW-1:0] ld_sec,
  input  logic [FW-1:0] ld_min,
  input  logic [FW-1:0] ld_hour,
  output logic [FW-1:0] sec,
  output logic [FW-1:0] min,
  output logic [FW-1:0] hour,
  output logic          day_step,
  output logic          p1,
  output logic          p10
);
  localparam int NF = 3;

  logic [FW-1:0] ld_v [NF];
  logic [FW-1:0] vals [NF];
  logic [NF-1:0] wrap_w;
  logic [NF:0]   adv;

  assign ld_v[0] = ld_sec;
  assign ld_v[1] = ld_min;
  assign ld_v[2] = ld_hour;
  assign adv     = {wrap_w, step};

  for (genvar g = 0; g < NF; g++) begin : g_fld
    cal_bcd_wrap #(.FIRST(8'h00)) u_fld (
      .clk(clk), .rst_n(rst_n), .adv(adv[g]), .ld(ld), .ld_val(ld_v[g]),
      .last_val((g == NF - 1) ? 8'h23 : 8'h59),
      .val(vals[g]), .wrap(wrap_w[g])
    );
  end

  assign sec      = vals[0];
  assign min      = vals[1];
  assign hour     = vals[2];
  assign day_step = wrap_w[NF-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1  <= 1'b0;
      p10 <= 1'b0;
    end else begin
      p1  <= step && !ld;
      p10 <= step && !ld && (vals[0][3:0] == 4'd9);
    end
  end

  // R2: a date carry only leaves the last second of the day
  p_day_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    day_step |-> (sec == 8'h59 && min == 8'h59 && hour == 8'h23));
  // R2: the day carry returns all three fields to zero
  p_midnight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    day_step |=> (sec == 8'h00 && min == 8'h00 && hour == 8'h00));
endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          ld,
  input  logic [WW-1:0] ld_wday,
  input  logic [FW-1:0] ld_day,
  input  logic [FW-1:0] ld_mon,
  input  logic [YW-1:0] ld_year,
  output logic [WW-1:0] wday,
  output logic [FW-1:0] day,
  output logic [FW-1:0] mon,
  output logic [YW-1:0] year
);
  logic [YW-1:0] year_q;
  logic [WW-1:0] wday_q;
  logic          leap;
  logic [FW-1:0] last_day;
  logic          day_wrap, mon_wrap;

  assign leap     = is_leap(year_q);
  assign last_day = month_len(mon, leap);

  cal_bcd_wrap #(.FIRST(8'h01)) u_day (
    .clk(clk), .rst_n(rst_n), .adv(step), .ld(ld), .ld_val(ld_day),
    .last_val(last_day), .val(day), .wrap(day_wrap)
  );

  cal_bcd_wrap #(.FIRST(8'h01)) u_mon (
    .clk(clk), .rst_n(rst_n), .adv(day_wrap), .ld(ld), .ld_val(ld_mon),
    .last_val(8'h12), .val(mon), .wrap(mon_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      year_q <= 16'h2000;
      wday_q <= '0;
    end else if (ld) begin
      year_q <= ld_year;
      wday_q <= ld_wday;
    end else begin
      if (mon_wrap) year_q <= bcd_inc4(year_q);
      if (step)     wday_q <= (wday_q == WDAY_LAST) ? '0 : wday_q + 3'd1;
    end
  end

  assign year = year_q;
  assign wday = wday_q;

  // R6: every date step moves the weekday
  p_wday_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld) |=> !$stable(wday_q));
  // R7: new year's eve steps to the first of January
  p_new_year_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && mon == 8'h12 && day == 8'h31) |=> (mon == 8'h01 && day == 8'h01));
  // R5: February 28 of a common year steps to March
  p_feb_common_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && mon == 8'h02 && day == 8'h28 && !leap) |=> (mon == 8'h03));
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          clr,
  input  logic [FW-1:0] sec,
  input  logic [FW-1:0] min,
  input  logic [FW-1:0] hour,
  input  logic [WW-1:0] wday,
  input  logic [FW-1:0] a_sec,
  input  logic [FW-1:0] a_min,
  input  logic [FW-1:0] a_hour,
  input  logic [WW-1:0] a_wday,
  input  logic [3:0]    mask,
  input  logic          ge,
  output logic          hit,
  output logic          pend
);
  logic [3*FW-1:0] cur_k, alm_k;
  logic            wday_ok, match, match_q, rise;

  assign cur_k   = {mask[2] ? 8'h00 : hour,   mask[1] ? 8'h00 : min,   mask[0] ? 8'h00 : sec};
  assign alm_k   = {mask[2] ? 8'h00 : a_hour, mask[1] ? 8'h00 : a_min, mask[0] ? 8'h00 : a_sec};
  assign wday_ok = mask[3] || (wday == a_wday);
  assign match   = wday_ok && (ge ? (cur_k >= alm_k) : (cur_k == alm_k));
  assign rise    = match && !match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b1;
      hit     <= 1'b0;
      pend    <= 1'b0;
    end else begin
      match_q <= match;
      if (ld) begin
        hit  <= 1'b0;
        pend <= 1'b0;
      end else if (rise) begin
        hit  <= 1'b1;
        pend <= 1'b1;
      end else begin
        hit <= 1'b0;
        if (clr) pend <= 1'b0;
      end
    end
  end

  // R11: an event always leaves the flag pending
  p_hit_pend_r11: assert property (@(posedge clk) disable iff (!rst_n) hit |-> pend);
  // R11: the event lasts a single cycle
  p_hit_single_r11: assert property (@(posedge clk) disable iff (!rst_n) hit |=> !hit);
  // R12: a load wipes the alarm state
  p_load_wipe_r12: assert property (@(posedge clk) disable iff (!rst_n) ld |=> (!pend && !hit));
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          load_en,
  input  logic [FW-1:0] load_sec,
  input  logic [FW-1:0] load_min,
  input  logic [FW-1:0] load_hour,
  input  logic [WW-1:0] load_wday,
  input  logic [FW-1:0] load_day,
  input  logic [FW-1:0] load_mon,
  input  logic [YW-1:0] load_year,
  input  logic [FW-1:0] alarm_sec,
  input  logic [FW-1:0] alarm_min,
  input  logic [FW-1:0] alarm_hour,
  input  logic [WW-1:0] alarm_wday,
  input  logic [3:0]    alarm_mask,
  input  logic          alarm_ge,
  input  logic          alarm_clear,
  output logic [FW-1:0] cur_sec,
  output logic [FW-1:0] cur_min,
  output logic [FW-1:0] cur_hour,
  output logic [WW-1:0] cur_wday,
  output logic [FW-1:0] cur_day,
  output logic [FW-1:0] cur_mon,
  output logic [YW-1:0] cur_year,
  output logic          pulse_1s,
  output logic          pulse_10s,
  output logic          alarm_hit,
  output logic          alarm_pend
);
  logic day_step;

  cal_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .step(tick_1hz), .ld(load_en),
    .ld_sec(load_sec), .ld_min(load_min), .ld_hour(load_hour),
    .sec(cur_sec), .min(cur_min), .hour(cur_hour),
    .day_step(day_step), .p1(pulse_1s), .p10(pulse_10s)
  );

  cal_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .step(day_step), .ld(load_en),
    .ld_wday(load_wday), .ld_day(load_day), .ld_mon(load_mon), .ld_year(load_year),
    .wday(cur_wday), .day(cur_day), .mon(cur_mon), .year(cur_year)
  );

  cal_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .ld(load_en), .clr(alarm_clear),
    .sec(cur_sec), .min(cur_min), .hour(cur_hour), .wday(cur_wday),
    .a_sec(alarm_sec), .a_min(alarm_min), .a_hour(alarm_hour), .a_wday(alarm_wday),
    .mask(alarm_mask), .ge(alarm_ge), .hit(alarm_hit), .pend(alarm_pend)
  );

  // R3: without tick or load every field holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !load_en) |=> $stable({cur_sec, cur_min, cur_hour, cur_wday, cur_day, cur_mon, cur_year}));
  // R8: the ten-second strobe rides with the second strobe on a zero units digit
  p_ten_sec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_10s |-> (pulse_1s && cur_sec[3:0] == 4'h0));
  // R12: a load lands exactly and suppresses the strobe
  p_load_exact_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cur_sec == $past(load_sec) && cur_year == $past(load_year) && !pulse_1s));
endmodule

// File: tb/bcd_calendar_clock_test.sv
module bcd_calendar_clock_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, load_en = 1'b0;
  logic [7:0] load_sec = '0, load_min = '0, load_hour = '0, load_day = 8'h01, load_mon = 8'h01;
  logic [2:0] load_wday = '0;
  logic [15:0] load_year = 16'h2000;
  logic [7:0] alarm_sec = 8'h00, alarm_min = 8'h00, alarm_hour = 8'h99;
  logic [2:0] alarm_wday = '0;
  logic [3:0] alarm_mask = 4'b1000;
  logic alarm_ge = 1'b0, alarm_clear = 1'b0;
  logic [7:0] cur_sec, cur_min, cur_hour, cur_day, cur_mon;
  logic [2:0] cur_wday;
  logic [15:0] cur_year;
  logic pulse_1s, pulse_10s, alarm_hit, alarm_pend;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  int leap_years [6] = '{1900, 2000, 2023, 2024, 2100, 2400};

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcd_calendar_clock uut (.*);

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  function automatic bit leap_int(input int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic int mlen_int(input int m, input int y);
    if (m == 2) return leap_int(y) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick_1hz = 1'b1;
    @(negedge clk) tick_1hz = 1'b0;
  endtask

  task automatic do_load(input logic [7:0] h, m, s, input logic [2:0] wd,
                         input logic [7:0] d, mo, input logic [15:0] y, input bit with_tick);
    @(negedge clk);
    load_hour = h; load_min = m; load_sec = s; load_wday = wd;
    load_day = d; load_mon = mo; load_year = y;
    load_en = 1'b1; tick_1hz = with_tick;
    @(negedge clk);
    load_en = 1'b0; tick_1hz = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sec", 32'(cur_sec), 32'h00);
    chk("R1 min/hour", 32'({cur_hour, cur_min}), 32'h0000);
    chk("R1 wday", 32'(cur_wday), 32'd0);
    chk("R1 date", 32'({cur_day, cur_mon}), 32'h0101);
    chk("R1 year", 32'(cur_year), 32'h2000);
    chk("R1 flags", 32'({pulse_1s, pulse_10s, alarm_hit, alarm_pend}), 32'd0);
  endtask

  task automatic t_count_and_hold();
    do_load(8'h10, 8'h20, 8'h08, 3'd2, 8'h15, 8'h06, 16'h2021, 1'b0);
    repeat (5) @(negedge clk);
    chk("R3 hold time", 32'({cur_hour, cur_min, cur_sec}), 32'h102008);
    chk("R3 hold date", 32'({cur_day, cur_mon}), 32'h1506);
    do_tick();
    chk("R2 sec 09", 32'(cur_sec), 32'h09);
    chk("R8 p1 on 09", 32'({pulse_1s, pulse_10s}), 32'b10);
    @(negedge clk);
    chk("R8 p1 one cycle", 32'(pulse_1s), 32'd0);
    do_tick();
    chk("R1 sec 10 digits", 32'(cur_sec), 32'h10);
    chk("R8 p10 on 10", 32'({pulse_1s, pulse_10s}), 32'b11);
    do_load(8'h10, 8'h20, 8'h59, 3'd2, 8'h15, 8'h06, 16'h2021, 1'b0);
    do_tick();
    chk("R2 min carry", 32'({cur_hour, cur_min, cur_sec}), 32'h102100);
    chk("R8 p10 on 59", 32'(pulse_10s), 32'd1);
  endtask

  task automatic t_rollovers();
    do_load(8'h23, 8'h59, 8'h59, 3'd6, 8'h31, 8'h12, 16'h1999, 1'b0);
    do_tick();
    chk("R2 midnight", 32'({cur_hour, cur_min, cur_sec}), 32'h000000);
    chk("R6 wday 6->0", 32'(cur_wday), 32'd0);
    chk("R7 new year date", 32'({cur_day, cur_mon}), 32'h0101);
    chk("R7 year 2000", 32'(cur_year), 32'h2000);
    do_load(8'h23, 8'h59, 8'h59, 3'd3, 8'h31, 8'h12, 16'h9999, 1'b0);
    do_tick();
    chk("R7 year 9999->0000", 32'(cur_year), 32'h0000);
    chk("R6 wday 3->4", 32'(cur_wday), 32'd4);
    do_load(8'h23, 8'h59, 8'h59, 3'd0, 8'h30, 8'h01, 16'h2023, 1'b0);
    do_tick();
    chk("R4 jan 30->31", 32'({cur_day, cur_mon}), 32'h3101);
  endtask

  task automatic t_month_lengths();
    for (int m = 1; m <= 12; m++) begin
      int nm;
      nm = (m == 12) ? 1 : m + 1;
      do_load(8'h23, 8'h59, 8'h59, 3'd1, to_bcd(mlen_int(m, 2023))[7:0],
              to_bcd(m)[7:0], 16'h2023, 1'b0);
      do_tick();
      chk($sformatf("R4 end of month %0d", m), 32'({cur_day, cur_mon}),
          32'({8'h01, to_bcd(nm)[7:0]}));
    end
  endtask

  task automatic t_leap();
    for (int i = 0; i < 6; i++) begin
      int y;
      y = leap_years[i];
      do_load(8'h23, 8'h59, 8'h59, 3'd1, 8'h28, 8'h02, to_bcd(y), 1'b0);
      do_tick();
      chk($sformatf("R5 feb 28 of %0d", y), 32'({cur_day, cur_mon}),
          leap_int(y) ? 32'h2902 : 32'h0103);
      if (leap_int(y)) begin
        do_load(8'h23, 8'h59, 8'h59, 3'd1, 8'h29, 8'h02, to_bcd(y), 1'b0);
        do_tick();
        chk($sformatf("R5 feb 29 of %0d", y), 32'({cur_day, cur_mon}), 32'h0103);
      end
    end
  endtask

  task automatic t_alarm_equal();
    alarm_ge = 1'b0; alarm_mask = 4'b1000;
    alarm_hour = 8'h12; alarm_min = 8'h00; alarm_sec = 8'h05;
    do_load(8'h12, 8'h00, 8'h04, 3'd1, 8'h01, 8'h01, 16'h2022, 1'b0);
    do_tick();
    chk("R11 no event before edge", 32'(alarm_pend), 32'd0);
    @(negedge clk);
    chk("R9 equal match event", 32'({alarm_hit, alarm_pend}), 32'b11);
    @(negedge clk);
    chk("R11 hit single, pend held", 32'({alarm_hit, alarm_pend}), 32'b01);
    @(negedge clk) alarm_clear = 1'b1;
    @(negedge clk) alarm_clear = 1'b0;
    chk("R11 clear, persisting match ignored", 32'({alarm_hit, alarm_pend}), 32'b00);
    alarm_mask = 4'b1110; alarm_sec = 8'h30;
    do_load(8'h05, 8'h17, 8'h28, 3'd4, 8'h01, 8'h01, 16'h2022, 1'b0);
    do_tick();
    @(negedge clk);
    chk("R9 masked no match at 29", 32'(alarm_pend), 32'd0);
    do_tick();
    @(negedge clk);
    chk("R9 masked match at 30", 32'(alarm_pend), 32'd1);
  endtask

  task automatic t_alarm_ge_and_load();
    alarm_ge = 1'b1; alarm_mask = 4'b1000;
    alarm_hour = 8'h10; alarm_min = 8'h00; alarm_sec = 8'h00;
    do_load(8'h09, 8'h59, 8'h58, 3'd2, 8'h01, 8'h01, 16'h2022, 1'b0);
    do_tick();
    @(negedge clk);
    chk("R10 before alarm time", 32'(alarm_pend), 32'd0);
    do_tick();
    @(negedge clk);
    chk("R10 reaches alarm time", 32'(alarm_pend), 32'd1);
    @(negedge clk) alarm_clear = 1'b1;
    @(negedge clk) alarm_clear = 1'b0;
    do_tick();
    @(negedge clk);
    chk("R10 past alarm no new event", 32'({alarm_hit, alarm_pend}), 32'b00);
    do_load(8'h09, 8'h59, 8'h59, 3'd2, 8'h01, 8'h01, 16'h2022, 1'b0);
    do_tick();
    @(negedge clk);
    chk("R10 pending before load", 32'(alarm_pend), 32'd1);
    do_load(8'h03, 8'h04, 8'h05, 3'd5, 8'h20, 8'h07, 16'h2030, 1'b1);
    chk("R12 load beats tick", 32'({cur_hour, cur_min, cur_sec}), 32'h030405);
    chk("R12 load date", 32'({cur_day, cur_mon, cur_year}), 32'h20072030);
    chk("R12 no strobe", 32'({pulse_1s, pulse_10s}), 32'd0);
    chk("R12 pending cleared", 32'({alarm_hit, alarm_pend}), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_and_hold();
    t_rollovers();
    t_month_lengths();
    t_leap();
    t_alarm_equal();
    t_alarm_ge_and_load();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule